// File: doc/BRIEF.md
# SDRAM Power-Mode Command Sequencer

This block sits between a memory-configuration register port and an SDRAM command engine. It holds the controller enable, two self-refresh request bits, the clock-pin source select, a software pin value and three plain mode bits: extra wait cycle, double-rate select and debug-port enable. From these bits it produces three command requests towards the command engine: mode-register set, self-refresh entry and auto-refresh. It also produces a standby indication.

Software turns the controller on by writing the enable bit. That 0-to-1 transition produces a single mode-register-set request. Setting either self-refresh bit while enabled and idle sends the memory into self-refresh standby, where it stays until both bits are clear. Leaving standby always runs a burst of auto-refresh commands before the sequencer is idle again. The SDRAM clock pin carries either the memory clock or a software-written bit.

Top module: `sdram_pwr_seq`

## Requirements
- R1: Register 0 (regSel=0) holds enable at bit 0, self-refresh request A at bit 1, pin select at bit 2, pin value at bit 3, extra wait at bit 4, double-rate select at bit 5 and debug-port enable at bit 6; bit 7 reads 0. Register 1 (regSel=1) holds self-refresh request B at bit 0 and reads 0 elsewhere. regRdData shows the register picked by regSel in the same cycle, and a write lands on the next clock edge.
- R2: A write that takes the enable bit from 0 to 1 yields exactly one mrsReq. mrsReq rises on the clock edge after the write edge and is held until mrsAck is sampled high.
- R3: While enabled, idle and with no mode-register set owed, a set self-refresh bit raises srEntryReq. srEntryReq is held until srEntryAck, and inStandby is high on the following cycle.
- R4: inStandby stays high for as long as either self-refresh bit is set.
- R5: Once both self-refresh bits are clear in standby, arefReq rises on the next edge. It stays high until NREF acknowledges (default 4) have been sampled, and then the block is idle.
- R6: Either self-refresh bit alone is enough to enter and to hold standby.
- R7: sdClkPin equals memClk when the pin-select bit is 0, and equals the pin-value bit when it is 1.
- R8: At most one of mrsReq, srEntryReq, arefReq and inStandby is high at a time. An owed mode-register set is served before a self-refresh entry.
- R9: While the enable bit is 0, no request is started from idle, and a self-refresh bit set then has no effect. An owed mode-register set is dropped if enable is cleared before it starts.
- R10: After reset all register bits are 0, the block is idle with every request and inStandby low, and sdClkPin follows memClk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| memClk | input | 1 | SDRAM clock routed to the pin when selected |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 mode, 1 config |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| mrsAck | input | 1 | Command engine accepted the mode-register set |
| srEntryAck | input | 1 | Command engine accepted the self-refresh entry |
| arefAck | input | 1 | Command engine accepted one auto-refresh |
| mrsReq | output | 1 | Mode-register-set request |
| srEntryReq | output | 1 | Self-refresh entry request |
| arefReq | output | 1 | Auto-refresh request |
| inStandby | output | 1 | SDRAM is held in self-refresh |
| sdClkPin | output | 1 | SDRAM clock pin output |

## Verification
The hardest situation to reach is a mode-register set owed at the same moment as self-refresh activity. One path is an enable that rises while the memory sits in standby; another is an enable that falls and rises again around a standby exit. The stimulus clears and then sets the enable bit while a self-refresh bit is held. It then releases self-refresh and checks that the owed set follows the full auto-refresh burst. It also disables the block inside standby and checks that the burst still runs while the owed set is dropped. A behavioural model in the bench tracks every register and sequence step. The bench answers requests with several acknowledge latencies, including same-cycle acceptance of every burst command.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MRS  = 3'd1,
    ST_SRE  = 3'd2,
    ST_STBY = 3'd3,
    ST_AREF = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic mrsTaken;
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic enable;
    logic srAny;
    logic mrsPending;
    logic burstLast;
  } seqStatus_t;

  localparam int MODE_EN   = 0;
  localparam int MODE_SRA  = 1;
  localparam int MODE_PSEL = 2;
  localparam int MODE_PVAL = 3;
  localparam int MODE_WAIT = 4;
  localparam int MODE_DDR  = 5;
  localparam int MODE_DBG  = 6;
  localparam int MODE_BITS = 7;
  localparam int CFG_SRB   = 0;

endpackage

// File: rtl/sdram_pwr_dp.sv
module sdram_pwr_dp
  import sdram_pwr_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int NREF  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             memClk,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  input  seqStrobe_t       strobe,
  output seqStatus_t       status,
  output logic [REG_W-1:0] regRdData,
  output logic             sdClkPin
);

  localparam int CNT_W = (NREF > 1) ? $clog2(NREF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NREF - 1);

  logic [MODE_BITS-1:0] modeBits;
  logic                 cfgSrB;
  logic                 mrsOwed;
  logic [CNT_W-1:0]     burstCnt;
  logic                 modeWr;
  logic                 cfgWr;
  logic                 enRise;

  assign modeWr = regWrEn && !regSel;
  assign cfgWr  = regWrEn && regSel;
  assign enRise = modeWr && regWrData[MODE_EN] && !modeBits[MODE_EN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBits <= '0;
      cfgSrB   <= 1'b0;
    end else begin
      if (modeWr) modeBits <= regWrData[MODE_BITS-1:0];
      if (cfgWr)  cfgSrB   <= regWrData[CFG_SRB];
    end
  end

  // owed mode-register set: set on enable rise, dropped on disable or start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mrsOwed <= 1'b0;
    end else if (enRise) begin
      mrsOwed <= 1'b1;
    end else if (!modeBits[MODE_EN] || strobe.mrsTaken) begin
      mrsOwed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.cntClr) begin
      burstCnt <= '0;
    end else if (strobe.cntInc) begin
      burstCnt <= burstCnt + 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel) begin
      regRdData[CFG_SRB] = cfgSrB;
    end else begin
      regRdData[MODE_BITS-1:0] = modeBits;
    end
  end

  assign sdClkPin = modeBits[MODE_PSEL] ? modeBits[MODE_PVAL] : memClk;

  assign status.enable     = modeBits[MODE_EN];
  assign status.srAny      = modeBits[MODE_SRA] | cfgSrB;
  assign status.mrsPending = mrsOwed;
  assign status.burstLast  = (burstCnt == CNT_LAST);

endmodule

// File: rtl/sdram_pwr_ctrl.sv
module sdram_pwr_ctrl
  import sdram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t status,
  input  logic       mrsAck,
  input  logic       srEntryAck,
  input  logic       arefAck,
  output seqStrobe_t strobe,
  output logic       mrsReq,
  output logic       srEntryReq,
  output logic       arefReq,
  output logic       inStandby
);

  seqState_t curState;
  seqState_t nxtState;

  always_comb begin
    nxtState = curState;
    strobe   = '0;
    unique case (curState)
      ST_IDLE: begin
        strobe.cntClr = 1'b1;
        if (status.enable && status.mrsPending) begin
          nxtState        = ST_MRS;
          strobe.mrsTaken = 1'b1;
        end else if (status.enable && status.srAny) begin
          nxtState = ST_SRE;
        end
      end
      ST_MRS:  if (mrsAck) nxtState = ST_IDLE;
      ST_SRE:  if (srEntryAck) nxtState = ST_STBY;
      ST_STBY: begin
        strobe.cntClr = 1'b1;
        if (!status.srAny) nxtState = ST_AREF;
      end
      ST_AREF: begin
        if (arefAck) begin
          if (status.burstLast) nxtState = ST_IDLE;
          else strobe.cntInc = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  assign mrsReq     = (curState == ST_MRS);
  assign srEntryReq = (curState == ST_SRE);
  assign arefReq    = (curState == ST_AREF);
  assign inStandby  = (curState == ST_STBY);

endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq
  import sdram_pwr_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int NREF  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             memClk,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             mrsAck,
  input  logic             srEntryAck,
  input  logic             arefAck,
  output logic             mrsReq,
  output logic             srEntryReq,
  output logic             arefReq,
  output logic             inStandby,
  output logic             sdClkPin
);

  seqStrobe_t strobe;
  seqStatus_t status;
  logic       ctlEnable;
  logic       srAny;

  sdram_pwr_dp #(.REG_W(REG_W), .NREF(NREF)) dpI (
    .clk(clk), .rstN(rstN), .memClk(memClk),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .strobe(strobe), .status(status),
    .regRdData(regRdData), .sdClkPin(sdClkPin)
  );

  sdram_pwr_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .status(status),
    .mrsAck(mrsAck), .srEntryAck(srEntryAck), .arefAck(arefAck),
    .strobe(strobe),
    .mrsReq(mrsReq), .srEntryReq(srEntryReq), .arefReq(arefReq),
    .inStandby(inStandby)
  );

  assign ctlEnable = status.enable;
  assign srAny     = status.srAny;

endmodule

// File: rtl/sdram_pwr_chk.sv
module sdram_pwr_chk #(
  parameter int NREF = 4
) (
  input logic clk,
  input logic rstN,
  input logic ctlEnable,
  input logic srAny,
  input logic mrsReq,
  input logic mrsAck,
  input logic srEntryReq,
  input logic srEntryAck,
  input logic arefReq,
  input logic arefAck,
  input logic inStandby
);

  int unsigned burstAcks;

  always_ff @(posedge clk) begin
    if (!rstN) burstAcks <= 0;
    else if (arefReq && arefAck) burstAcks <= burstAcks + 1;
    else if (!arefReq) burstAcks <= 0;
  end

  // R8
  one_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mrsReq, srEntryReq, arefReq, inStandby}));

  // R2
  mrs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mrsReq && !mrsAck |=> mrsReq);

  // R9
  mrs_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mrsReq) |-> $past(ctlEnable));

  // R3
  sre_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    srEntryReq && !srEntryAck |=> srEntryReq);

  // R3
  sre_to_stby_chk: assert property (@(posedge clk) disable iff (!rstN)
    srEntryReq && srEntryAck |=> inStandby);

  // R9
  sre_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srEntryReq) |-> $past(ctlEnable && srAny));

  // R4
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    inStandby && srAny |=> inStandby);

  // R5
  aref_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    inStandby && !srAny |=> arefReq);

  // R5
  aref_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(arefReq) |-> (burstAcks == NREF));

endmodule

bind sdram_pwr_seq sdram_pwr_chk #(.NREF(NREF)) chkI (
  .clk(clk), .rstN(rstN), .ctlEnable(ctlEnable), .srAny(srAny),
  .mrsReq(mrsReq), .mrsAck(mrsAck),
  .srEntryReq(srEntryReq), .srEntryAck(srEntryAck),
  .arefReq(arefReq), .arefAck(arefAck), .inStandby(inStandby)
);

// File: tb/sdram_pwr_seq_test.sv
`timescale 1ns/1ps
module sdram_pwr_seq_test;

  localparam int NREF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       memClk = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       mrsAck = 1'b0;
  logic       srEntryAck = 1'b0;
  logic       arefAck = 1'b0;
  logic       mrsReq, srEntryReq, arefReq, inStandby, sdClkPin;

  sdram_pwr_seq #(.REG_W(8), .NREF(NREF)) uut (
    .clk(clk), .rstN(rstN), .memClk(memClk),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData),
    .mrsAck(mrsAck), .srEntryAck(srEntryAck), .arefAck(arefAck),
    .mrsReq(mrsReq), .srEntryReq(srEntryReq), .arefReq(arefReq),
    .inStandby(inStandby), .sdClkPin(sdClkPin)
  );

  always #4 clk = ~clk;
  always @(posedge clk) #1 memClk <= ~memClk;

  int totalCnt = 0;
  int failCnt = 0;
  int ackLat = 1;
  int ackWait = 0;

  // reference model: 0 idle, 1 mode set, 2 sr entry, 3 standby, 4 refresh burst
  int mSt = 0;
  int mAcks = 0;
  int mMrsIssued = 0;
  int dutMrsRises = 0;
  bit mEn, mSrA, mSrB, mSel, mGpo, mWait, mDdr, mDbg, mPend;
  bit prevMrs = 1'b0;

  always @(posedge clk) begin
    bit taken;
    bit rise;
    taken = 1'b0;
    if (!rstN) begin
      mSt = 0; mAcks = 0; mPend = 0;
      {mEn, mSrA, mSrB, mSel, mGpo, mWait, mDdr, mDbg} = '0;
    end else begin
      case (mSt)
        0: if (mEn && mPend) begin mSt = 1; taken = 1'b1; mMrsIssued++; end
           else if (mEn && (mSrA || mSrB)) mSt = 2;
        1: if (mrsAck) mSt = 0;
        2: if (srEntryAck) mSt = 3;
        3: if (!(mSrA || mSrB)) begin mSt = 4; mAcks = 0; end
        4: if (arefAck) begin mAcks++; if (mAcks == NREF) mSt = 0; end
        default: mSt = 0;
      endcase
      rise = regWrEn && !regSel && regWrData[0] && !mEn;
      if (rise) mPend = 1'b1;
      else if (!mEn || taken) mPend = 1'b0;
      if (regWrEn) begin
        if (!regSel) begin
          mEn = regWrData[0]; mSrA = regWrData[1]; mSel = regWrData[2];
          mGpo = regWrData[3]; mWait = regWrData[4]; mDdr = regWrData[5];
          mDbg = regWrData[6];
        end else begin
          mSrB = regWrData[0];
        end
      end
    end
  end

  // acknowledge responder driven from the model's expected requests
  always @(negedge clk) begin
    if (mSt == 1 || mSt == 2 || mSt == 4) begin
      if (ackWait >= ackLat) begin
        mrsAck = (mSt == 1); srEntryAck = (mSt == 2); arefAck = (mSt == 4);
        ackWait = 0;
      end else begin
        mrsAck = 1'b0; srEntryAck = 1'b0; arefAck = 1'b0;
        ackWait++;
      end
    end else begin
      mrsAck = 1'b0; srEntryAck = 1'b0; arefAck = 1'b0;
      ackWait = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [7:0] expRd;
    logic       expPin;
    #2;
    expRd = regSel ? {7'b0, mSrB} : {1'b0, mDbg, mDdr, mWait, mGpo, mSel, mSrA, mEn};
    expPin = mSel ? mGpo : memClk;
    chk(regRdData == expRd, rstN ? "R1 readback" : "R10 reset readback", regRdData, expRd);
    chk(mrsReq == (mSt == 1), "R2 mrsReq", mrsReq, mSt == 1);
    chk(srEntryReq == (mSt == 2), "R3 srEntryReq", srEntryReq, mSt == 2);
    chk(inStandby == (mSt == 3), "R4 inStandby", inStandby, mSt == 3);
    chk(arefReq == (mSt == 4), "R5 arefReq", arefReq, mSt == 4);
    chk(sdClkPin == expPin, "R7 sdClkPin", sdClkPin, expPin);
    if (mrsReq && !prevMrs) dutMrsRises++;
    prevMrs = mrsReq;
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitSt(input int st);
    for (int i = 0; i < 500 && mSt != st; i++) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    failCnt++; totalCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #3;
    // R10: reset state seen at the ports
    chk(!mrsReq && !srEntryReq && !arefReq && !inStandby, "R10 requests low", 0, 0);
    chk(regRdData == 8'h00, "R10 regs clear", regRdData, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: plain bits and read masks while disabled
    wr(1'b0, 8'hF0);
    regSel = 1'b1;
    wr(1'b1, 8'hFF);  // R9: request B while disabled must be ignored
    regSel = 1'b1;
    repeat (10) @(negedge clk);
    #3;
    chk(!srEntryReq && !inStandby, "R9 disabled sr ignored", inStandby, 0);
    wr(1'b1, 8'h00);
    regSel = 1'b0;
    wr(1'b0, 8'h02);  // R9: request A while disabled
    repeat (8) @(negedge clk);
    #3;
    chk(!srEntryReq && !inStandby, "R9 disabled srA ignored", inStandby, 0);
    wr(1'b0, 8'h00);

    // R2: enable rise, latency 2
    ackLat = 2;
    wr(1'b0, 8'h01);
    waitSt(0);

    // R3/R4/R5: request A, hold, release
    ackLat = 1;
    wr(1'b0, 8'h03);
    waitSt(3);
    repeat (20) @(negedge clk);
    wr(1'b0, 8'h01);
    waitSt(0);

    // R6: request B alone, burst acked every cycle
    ackLat = 0;
    wr(1'b1, 8'h01);
    waitSt(3);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h00);
    waitSt(0);

    // R6: both, clear A only keeps standby
    ackLat = 3;
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h01);
    waitSt(3);
    wr(1'b0, 8'h01);
    repeat (6) @(negedge clk);
    #3;
    chk(inStandby, "R6 B alone holds standby", inStandby, 1);
    wr(1'b1, 8'h00);
    waitSt(0);

    // R8: enable rise together with request A -> mode set first
    ackLat = 1;
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h03);
    waitSt(3);
    // enable toggled inside standby: owed set served after the burst
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h03);
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h01);
    waitSt(1);
    waitSt(0);

    // R9: disable inside standby, burst still runs, owed set dropped
    wr(1'b0, 8'h03);
    waitSt(3);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h01);  // owed set created
    wr(1'b0, 8'h00);  // and dropped by disabling
    waitSt(0);
    repeat (6) @(negedge clk);

    // R2: enable dropped while mode set waits for ack
    ackLat = 5;
    wr(1'b0, 8'h01);
    wr(1'b0, 8'h00);
    waitSt(0);

    // R7: pin select and software value
    wr(1'b0, 8'h04);
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h0C);
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h08);
    repeat (4) @(negedge clk);

    // R2: one mode set per enable rise over the whole run
    chk(dutMrsRises == mMrsIssued, "R2 mode-set count", dutMrsRises, mMrsIssued);
    finishRun();
  end

endmodule